// File: doc/BRIEF.md
# Carry-Chaining Instruction Modifier Unit

This block sits in the decode stage of a 64-bit core. It lets a run of word-sized additions be chained into one wide addition without a flags bit. A prefix instruction carries a 16-bit immediate and names a general register. The immediate holds eight 2-bit carry roles, one for each of the next eight instructions the decoder accepts. While this window of eight instructions is open, each add takes its role from the low end of the immediate, and the immediate then shifts right by one slot.

The named register is the carry path. An add with the carry-in role adds bit 0 of that register as its incoming carry. An add with the carry-out role writes its carry-out, zero-extended to 64 bits, back into the same register. An add with no role is a plain 64-bit add. A 256-bit sum is formed by four adds under one prefix: the first with carry-out only, the next three with both roles. The final carry is left in the named register, which makes a 257-bit result.

The unit contains a small register file. The rest of the core loads it through a writeback port and reads it through one read port. Each executed add is reported one cycle later on a registered result port.

Top module: `carry_chain_unit`

## Requirements
- R1: After reset every register reads zero, the window is closed, and the first add reports role 0 (none) and carry-out 0.
- R2: A valid prefix (`dec_valid` and `dec_is_prefix`) loads its immediate and takes `dec_rd` as the carry register. The k-th following add gets role `imm[2k+1:2k]`, starting with k=0. Role codes: 0 = none, 1 = carry-in, 2 = carry-out, 3 = both. `res_role` is bit 0 = carry-in, bit 1 = carry-out.
- R3: Only a valid non-prefix instruction uses up a slot. Cycles with `dec_valid` low leave the remaining roles and the slot count unchanged.
- R4: With carry-in active, the add computes ra + rb + (bit 0 of the carry register). The other 63 bits of that register have no effect.
- R5: With carry-out active, the carry register becomes {63 zeros, carry-out} at the same edge that writes the sum. When `dec_rd` names the carry register, the carry write wins.
- R6: With neither role active, the add writes ra + rb mod 2^64 to `dec_rd` and leaves every other register unchanged.
- R7: A prefix that arrives while the window is still open throws away the remaining roles. It restarts the window with eight fresh slots from its own immediate and its own register.
- R8: Once eight adds have used up the window, every later add gets role none until the next prefix.
- R9: Four adds with roles carry-out, both, both, both form a correct 256-bit sum across four destination registers. The 257th bit is left in the carry register.
- R10: The writeback port (`ext_we`) writes `ext_data` to `ext_idx` at the clock edge. When an add or a carry write hits the same index in the same cycle, the add or carry write takes priority.
- R11: `res_valid`, `res_sum`, `res_role` and `res_cout` describe the add accepted at the previous edge. `res_valid` is low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | An instruction is accepted by decode this cycle |
| dec_is_prefix | input | 1 | The accepted instruction is the carry prefix |
| dec_imm | input | 16 | Role immediate of the prefix |
| dec_rd | input | 4 | Add destination, or the carry register for a prefix |
| dec_ra | input | 4 | First add source register |
| dec_rb | input | 4 | Second add source register |
| ext_we | input | 1 | Writeback port write enable |
| ext_idx | input | 4 | Writeback port register index |
| ext_data | input | 64 | Writeback port data |
| rd_idx | input | 4 | Read port register index |
| rd_data | output | 64 | Read port data (combinational) |
| res_valid | output | 1 | An add was executed at the previous edge |
| res_sum | output | 64 | Sum of that add |
| res_role | output | 2 | Role applied to that add |
| res_cout | output | 1 | Carry-out of that add |

## Verification
The hardest state to reach from the ports is a window that is changed part-way through. That covers a stall in the middle of the eight slots, a second prefix that replaces an unfinished window, and the ninth add after the window has run out. Each of these needs a prefix followed by an exact count of accepted and idle cycles. Directed sequences build each case explicitly and also run a 256-bit add whose carry ripples through all four words. A seeded random mix of prefixes, adds, stalls and writebacks then checks every result and a sampled register after each cycle against a bench model. The random mix includes adds whose destination is the carry register and writebacks that collide with an add.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned NUM_REGS = 16;
    localparam int unsigned NUM_SLOTS = 8;
    localparam int unsigned ROLE_W = 2;
    localparam int unsigned IMM_W = NUM_SLOTS * ROLE_W;
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    typedef enum logic [ROLE_W-1:0] {
        ROLE_NONE = 2'b00,
        ROLE_CIN  = 2'b01,
        ROLE_COUT = 2'b10,
        ROLE_BOTH = 2'b11
    } role_e;

    function automatic logic role_has_cin(input role_e r);
        return r[0];
    endfunction

    function automatic logic role_has_cout(input role_e r);
        return r[1];
    endfunction
endpackage

// File: rtl/ccu_shadow.sv
module ccu_shadow
    import ccu_pkg::*;
#(
    parameter int unsigned SLOTS = NUM_SLOTS,
    parameter int unsigned IW    = IDX_W,
    localparam int unsigned SW   = SLOTS * ROLE_W,
    localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_imm,
    input  logic [IW-1:0] load_reg,
    input  logic          advance,
    output role_e         cur_role,
    output logic [IW-1:0] carry_idx
);
    typedef struct packed {
        logic [SW-1:0] roles;
        logic [CW-1:0] left;
        logic [IW-1:0] creg;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.roles = load_imm;
            st_d.left  = CW'(SLOTS);
            st_d.creg  = load_reg;
        end else if (advance && st_q.left != '0) begin
            st_d.roles = st_q.roles >> ROLE_W;
            st_d.left  = st_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_role  = (st_q.left != '0) ? role_e'(st_q.roles[ROLE_W-1:0]) : ROLE_NONE;
    assign carry_idx = st_q.creg;

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(st_q.roles) && $stable(st_q.left)));

    a_r8_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= CW'(SLOTS));

    a_r7_prefix_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.left == CW'(SLOTS)));
endmodule

// File: rtl/ccu_adder.sv
module ccu_adder #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/ccu_regfile.sv
module ccu_regfile #(
    parameter int unsigned W   = 64,
    parameter int unsigned N   = 16,
    parameter int unsigned NRD = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx  [NRD],
    output logic [W-1:0]  rd_data [NRD],
    input  logic          ext_we,
    input  logic [IW-1:0] ext_idx,
    input  logic [W-1:0]  ext_data,
    input  logic          ins_we,
    input  logic [IW-1:0] ins_idx,
    input  logic [W-1:0]  ins_data,
    input  logic          cy_we,
    input  logic [IW-1:0] cy_idx,
    input  logic [W-1:0]  cy_data
);
    logic [W-1:0] regs_d [N];
    logic [W-1:0] regs_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) regs_d[i] = regs_q[i];
        if (ext_we) regs_d[ext_idx] = ext_data;
        if (ins_we) regs_d[ins_idx] = ins_data;
        if (cy_we)  regs_d[cy_idx]  = cy_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) regs_q[i] <= regs_d[i];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = regs_q[rd_idx[p]];
    end

    a_r10_ext_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we && !(ins_we && ins_idx == ext_idx) && !(cy_we && cy_idx == ext_idx))
        |=> (regs_q[$past(ext_idx)] == $past(ext_data)));
endmodule

// File: rtl/carry_chain_unit.sv
module carry_chain_unit
    import ccu_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned NREG  = NUM_REGS,
    parameter int unsigned SLOTS = NUM_SLOTS,
    localparam int unsigned IW   = $clog2(NREG),
    localparam int unsigned SW   = SLOTS * ROLE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic          dec_is_prefix,
    input  logic [SW-1:0] dec_imm,
    input  logic [IW-1:0] dec_rd,
    input  logic [IW-1:0] dec_ra,
    input  logic [IW-1:0] dec_rb,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_idx,
    input  logic [W-1:0]  ext_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic          res_valid,
    output logic [W-1:0]  res_sum,
    output logic [1:0]    res_role,
    output logic          res_cout
);
    localparam int unsigned P_A = 0;
    localparam int unsigned P_B = 1;
    localparam int unsigned P_C = 2;
    localparam int unsigned P_X = 3;
    localparam int unsigned NRD = 4;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] sum;
        logic [1:0]   role;
        logic         cout;
    } res_t;

    res_t res_d, res_q;

    logic          is_add, is_pfx;
    role_e         role;
    logic [IW-1:0] creg;
    logic [IW-1:0] rf_idx  [NRD];
    logic [W-1:0]  rf_data [NRD];
    logic          cin, cout;
    logic [W-1:0]  sum;

    assign is_add = dec_valid && !dec_is_prefix;
    assign is_pfx = dec_valid && dec_is_prefix;

    ccu_shadow #(.SLOTS(SLOTS), .IW(IW)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (is_pfx),
        .load_imm  (dec_imm),
        .load_reg  (dec_rd),
        .advance   (is_add),
        .cur_role  (role),
        .carry_idx (creg)
    );

    always_comb begin
        rf_idx[P_A] = dec_ra;
        rf_idx[P_B] = dec_rb;
        rf_idx[P_C] = creg;
        rf_idx[P_X] = rd_idx;
    end

    assign cin = role_has_cin(role) && rf_data[P_C][0];

    ccu_adder #(.W(W)) u_adder (
        .a    (rf_data[P_A]),
        .b    (rf_data[P_B]),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    ccu_regfile #(.W(W), .N(NREG), .NRD(NRD)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rf_idx),
        .rd_data  (rf_data),
        .ext_we   (ext_we),
        .ext_idx  (ext_idx),
        .ext_data (ext_data),
        .ins_we   (is_add),
        .ins_idx  (dec_rd),
        .ins_data (sum),
        .cy_we    (is_add && role_has_cout(role)),
        .cy_idx   (creg),
        .cy_data  ({{(W-1){1'b0}}, cout})
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = is_add;
        if (is_add) begin
            res_d.sum  = sum;
            res_d.role = role;
            res_d.cout = cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rd_data   = rf_data[P_X];
    assign res_valid = res_q.valid;
    assign res_sum   = res_q.sum;
    assign res_role  = res_q.role;
    assign res_cout  = res_q.cout;

    a_r5_carry_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && role_has_cout(role))
        |=> (rf_data[P_C][W-1:1] == '0 && rf_data[P_C][0] == res_q.cout));

    a_r6_plain_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && role == ROLE_NONE && dec_rd != creg && !(ext_we && ext_idx == creg))
        |=> $stable(rf_data[P_C]));

    a_r11_result_only_after_add: assert property (@(posedge clk) disable iff (!rst_n)
        !is_add |=> !res_q.valid);

    a_r4_cin_needs_role: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add && !role_has_cin(role))
        |=> (res_q.sum == $past(rf_data[P_A] + rf_data[P_B])));
endmodule

// File: tb/test_carry_chain_unit.sv
module test_carry_chain_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0, dec_is_prefix = 1'b0;
    logic [15:0] dec_imm = '0;
    logic [3:0]  dec_rd = '0, dec_ra = '0, dec_rb = '0;
    logic        ext_we = 1'b0;
    logic [3:0]  ext_idx = '0;
    logic [63:0] ext_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        res_valid;
    logic [63:0] res_sum;
    logic [1:0]  res_role;
    logic        res_cout;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] m_regs [16];
    logic [15:0] m_roles;
    int          m_left;
    logic [3:0]  m_creg;

    always #5 clk = ~clk;

    carry_chain_unit i_carry_chain_unit (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_prefix(dec_is_prefix),
        .dec_imm(dec_imm), .dec_rd(dec_rd), .dec_ra(dec_ra), .dec_rb(dec_rb),
        .ext_we(ext_we), .ext_idx(ext_idx), .ext_data(ext_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .res_valid(res_valid), .res_sum(res_sum), .res_role(res_role),
        .res_cout(res_cout)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [64:0] model_add(input logic [63:0] a, input logic [63:0] b,
                                              input logic c);
        return {1'b0, a} + {1'b0, b} + {64'd0, c};
    endfunction

    task automatic read_reg(input logic [3:0] idx, output logic [63:0] val);
        rd_idx = idx;
        #1;
        val = rd_data;
    endtask

    task automatic check_reg(input string tag, input logic [3:0] idx);
        logic [63:0] v;
        read_reg(idx, v);
        check(tag, v, m_regs[idx]);
    endtask

    // One cycle of stimulus; the model is updated as the design should be at the edge.
    task automatic step(input bit v, input bit pfx, input logic [15:0] imm,
                        input logic [3:0] rd, input logic [3:0] ra, input logic [3:0] rb,
                        input bit ewe, input logic [3:0] eidx, input logic [63:0] edata,
                        input string tag);
        logic [1:0]  role;
        logic [64:0] full;
        bit          add;
        @(negedge clk);
        dec_valid = v; dec_is_prefix = pfx; dec_imm = imm;
        dec_rd = rd; dec_ra = ra; dec_rb = rb;
        ext_we = ewe; ext_idx = eidx; ext_data = edata;
        add  = v && !pfx;
        role = (m_left != 0) ? m_roles[1:0] : 2'b00;
        full = model_add(m_regs[ra], m_regs[rb], role[0] & m_regs[m_creg][0]);
        @(posedge clk);
        #1;
        if (ewe) m_regs[eidx] = edata;
        if (add) begin
            m_regs[rd] = full[63:0];
            if (role[1]) m_regs[m_creg] = {63'd0, full[64]};
            if (m_left != 0) begin
                m_roles = m_roles >> 2;
                m_left--;
            end
        end else if (v && pfx) begin
            m_roles = imm; m_left = 8; m_creg = rd;
        end
        check({tag, " R11 res_valid"}, {63'd0, res_valid}, {63'd0, add});
        if (add) begin
            check({tag, " R6 res_sum"}, res_sum, full[63:0]);
            check({tag, " R2 res_role"}, {62'd0, res_role}, {62'd0, role});
            check({tag, " R5 res_cout"}, {63'd0, res_cout}, {63'd0, full[64]});
        end
        dec_valid = 1'b0; ext_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [63:0] d);
        step(0, 0, 0, 0, 0, 0, 1, idx, d, "R10 wb");
    endtask

    task automatic add_op(input logic [3:0] rd, input logic [3:0] ra, input logic [3:0] rb,
                          input string tag);
        step(1, 0, 0, rd, ra, rb, 0, 0, 0, tag);
    endtask

    task automatic prefix(input logic [15:0] imm, input logic [3:0] r);
        step(1, 1, imm, r, 0, 0, 0, 0, 0, "R2 prefix");
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 stall");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd20241012));
        for (int i = 0; i < 16; i++) m_regs[i] = '0;
        m_roles = '0; m_left = 0; m_creg = '0;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 16; i++) check_reg("R1 reset reg", 4'(i));
        rst_n = 1'b1;
        add_op(4'd1, 4'd2, 4'd3, "R1 first add");
        check("R1 role after reset", {62'd0, res_role}, 64'd0);

        // R4: only bit 0 of the carry register enters the add
        wr(4'd14, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(4'd2, 64'd10);
        wr(4'd3, 64'd20);
        prefix(16'h0001, 4'd14);
        add_op(4'd4, 4'd2, 4'd3, "R4 cin bit0 clear");
        check("R4 sum ignores upper carry bits", res_sum, 64'd30);
        wr(4'd14, 64'h8000_0000_0000_0001);
        prefix(16'h0001, 4'd14);
        add_op(4'd4, 4'd2, 4'd3, "R4 cin bit0 set");
        check("R4 sum with carry in", res_sum, 64'd31);

        // R9: 256-bit add, ripple through all four words
        for (int i = 0; i < 4; i++) begin
            wr(4'(1 + i), 64'hFFFF_FFFF_FFFF_FFFF);
            wr(4'(5 + i), (i == 0) ? 64'd1 : 64'd0);
        end
        wr(4'd15, 64'h1234);
        prefix(16'h00FE, 4'd15);
        for (int i = 0; i < 4; i++) add_op(4'(9 + i), 4'(1 + i), 4'(5 + i), "R9 chain");
        for (int i = 0; i < 4; i++) begin
            read_reg(4'(9 + i), v);
            check("R9 wide sum word", v, 64'd0);
        end
        read_reg(4'd15, v);
        check("R9 bit 256 in carry reg", v, 64'd1);

        // R3: stalls inside the window do not use up slots
        prefix(16'h0009, 4'd15);
        add_op(4'd9, 4'd1, 4'd5, "R3 slot0");
        check("R3 slot0 role", {62'd0, res_role}, 64'd1);
        idle(); idle(); idle();
        add_op(4'd9, 4'd1, 4'd5, "R3 slot1 after stall");
        check("R3 slot1 role", {62'd0, res_role}, 64'd2);

        // R7: a new prefix replaces the open window
        prefix(16'hFFFF, 4'd13);
        add_op(4'd9, 4'd1, 4'd5, "R7 old window");
        prefix(16'h0002, 4'd12);
        add_op(4'd9, 4'd1, 4'd5, "R7 new window");
        check("R7 new role", {62'd0, res_role}, 64'd2);
        read_reg(4'd12, v);
        check("R7 new carry reg written", v, 64'd1);
        add_op(4'd9, 4'd1, 4'd5, "R7 second slot");
        check("R7 second slot role", {62'd0, res_role}, 64'd0);

        // R8: after eight adds the window closes
        prefix(16'hFFFF, 4'd11);
        for (int i = 0; i < 8; i++) add_op(4'd10, 4'd1, 4'd5, "R8 in window");
        add_op(4'd10, 4'd1, 4'd5, "R8 ninth");
        check("R8 ninth role none", {62'd0, res_role}, 64'd0);

        // R5: carry write wins over the destination write
        prefix(16'h0002, 4'd9);
        add_op(4'd9, 4'd1, 4'd5, "R5 rd is carry reg");
        read_reg(4'd9, v);
        check("R5 carry wins", v, 64'd1);

        // R10: add wins over writeback to same index
        step(1, 0, 0, 4'd6, 4'd2, 4'd3, 1, 4'd6, 64'hDEAD, "R10 collide");
        check_reg("R10 add wins", 4'd6);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 8)
                step(1, 1, 16'($urandom), 4'($urandom), 0, 0,
                     $urandom_range(0, 3) == 0, 4'($urandom), {$urandom, $urandom}, "R7 rnd");
            else if (k < 70)
                step(1, 0, 0, 4'($urandom), 4'($urandom), 4'($urandom),
                     $urandom_range(0, 4) == 0, 4'($urandom), {$urandom, $urandom}, "R6 rnd");
            else if (k < 85)
                step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 rnd");
            else
                step(0, 0, 0, 0, 0, 0, 1, 4'($urandom), {$urandom, $urandom}, "R10 rnd");
            check_reg("R6 rnd reg", 4'($urandom));
            check_reg("R5 rnd carry reg", m_creg);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule